// File: doc/BRIEF.md
# Flag-Setting Byte ALU

This block is the arithmetic core of a small register-to-register processor. Each cycle it takes two operands and a three-bit operation code, and it returns a result of the same width through combinational logic. It also produces a zero indication and a carry indication. It adds, subtracts, takes bitwise AND, NOR and XOR, and shifts one operand right by a single place. Subtraction shares the adder: the second operand is inverted and one is carried in. The carry after a subtraction therefore reads as "first operand is not below the second", so one subtract serves as an unsigned compare.

Both flags come out straight from the datapath, for a caller that needs them at once. They are also loaded into a two-bit flag register on a rising clock edge when the flag-write input is high. Conditional branches later read the flags from that register. An operation code outside the defined set gives a result of zero and never changes the stored flags. Other operations come out of the defined set through operand choice: negation, bitwise NOT, doubling and decrement.

Top module: `alu8_core`

## Requirements
- R1: With `op_sel` = 0 (add), `result` equals (`opnd_a` + `opnd_b`) mod 256 and `res_carry` is the carry out of bit 7.
- R2: With `op_sel` = 1 (subtract), `result` equals (`opnd_a` - `opnd_b`) mod 256 and `res_carry` is 1 exactly when `opnd_a` >= `opnd_b` as unsigned numbers.
- R3: With `op_sel` = 2, 3 or 4, `result` is the bitwise AND, NOR or XOR of the operands respectively, and `res_carry` is 0.
- R4: With `op_sel` = 5 (shift), `result` is `opnd_a` shifted right by one with a 0 entering bit 7, `res_carry` equals `opnd_a` bit 0, and `opnd_b` has no effect.
- R5: For every operation code from 0 to 5, `res_zero` is 1 exactly when the 8-bit `result` is 0.
- R6: With `op_sel` = 6 or 7, `result`, `res_zero` and `res_carry` are all 0, and the stored flags keep their value even when `flag_we` is high.
- R7: On a rising edge with `rst` low, `flag_we` high and `op_sel` from 0 to 5, `zf_q` and `cf_q` take the values of `res_zero` and `res_carry`. With `flag_we` low they hold.
- R8: On a rising edge with `rst` high, `zf_q` and `cf_q` become 0 whatever `flag_we` is.
- R9: Adding 255 decrements modulo 256. Adding a value to itself doubles it, with carry equal to its old bit 7. NOR with a zero operand gives the bitwise NOT. Subtracting a value from zero gives its two's-complement negation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous reset, active high, clears stored flags |
| op_sel | input | 3 | Operation code: 0 add, 1 subtract, 2 AND, 3 NOR, 4 XOR, 5 shift right, 6-7 unused |
| opnd_a | input | 8 | First operand; the operand that is shifted |
| opnd_b | input | 8 | Second operand |
| flag_we | input | 1 | Load the flag register at the next rising edge |
| result | output | 8 | Combinational result |
| res_zero | output | 1 | Combinational zero indication |
| res_carry | output | 1 | Combinational carry indication |
| zf_q | output | 1 | Stored zero flag |
| cf_q | output | 1 | Stored carry flag |

## Verification
Equal operands in a subtraction are the case hardest to get right. There the carry must be set while the result is zero, which differs from every other operand pair, and only the last stage of the carry chain decides it. An off-by-one error in the compare would show up only there. The stimulus sweeps all 65,536 operand pairs under every operation code, so the equal-operand diagonal and the full-length carry ripples (255 + 1, 0 - 1) are all covered. Separate edge-timed sequences load the flag register with flag-write combined with reset, with unused codes, and with flag-write low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_NOR = 3'd3,
    OP_XOR = 3'd4,
    OP_RSH = 3'd5
  } alu_op_e;

  localparam int unsigned OP_W = 3;

  function automatic logic op_is_known(input logic [OP_W-1:0] code);
    return code <= OP_RSH;
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0]   chain;
  logic [W-1:0] b_eff;

  assign chain[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prop;
    assign b_eff[i]   = b[i] ^ sub;
    assign prop       = a[i] ^ b_eff[i];
    assign sum[i]     = prop ^ chain[i];
    assign chain[i+1] = (a[i] & b_eff[i]) | (prop & chain[i]);
  end

  assign cout = chain[W];

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_o,
  output logic [W-1:0] nor_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] shr_o,
  output logic         shr_out_bit
);

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign and_o[i] = a[i] & b[i];
    assign nor_o[i] = ~(a[i] | b[i]);
    assign xor_o[i] = a[i] ^ b[i];
    if (i == W - 1) begin : g_top
      assign shr_o[i] = 1'b0;
    end else begin : g_mid
      assign shr_o[i] = a[i+1];
    end
  end

  assign shr_out_bit = a[0];

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic z_in,
  input  logic c_in,
  output logic z_q,
  output logic c_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else if (load) begin
      z_q <= z_in;
      c_q <= c_in;
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int unsigned W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [alu8_pkg::OP_W-1:0] op_sel,
  input  logic [W-1:0]              opnd_a,
  input  logic [W-1:0]              opnd_b,
  input  logic                      flag_we,
  output logic [W-1:0]              result,
  output logic                      res_zero,
  output logic                      res_carry,
  output logic                      zf_q,
  output logic                      cf_q
);
  import alu8_pkg::*;

  logic [W-1:0] arith_sum;
  logic         arith_cout;
  logic [W-1:0] and_v, nor_v, xor_v, shr_v;
  logic         shr_bit;
  logic         is_sub;
  logic         known;

  assign is_sub = (op_sel == OP_SUB);
  assign known  = op_is_known(op_sel);

  alu8_addsub #(.W(W)) u_addsub (
    .a    (opnd_a),
    .b    (opnd_b),
    .sub  (is_sub),
    .sum  (arith_sum),
    .cout (arith_cout)
  );

  alu8_bitwise #(.W(W)) u_bitwise (
    .a           (opnd_a),
    .b           (opnd_b),
    .and_o       (and_v),
    .nor_o       (nor_v),
    .xor_o       (xor_v),
    .shr_o       (shr_v),
    .shr_out_bit (shr_bit)
  );

  always_comb begin
    result    = '0;
    res_carry = 1'b0;
    case (op_sel)
      OP_ADD, OP_SUB: begin
        result    = arith_sum;
        res_carry = arith_cout;
      end
      OP_AND: result = and_v;
      OP_NOR: result = nor_v;
      OP_XOR: result = xor_v;
      OP_RSH: begin
        result    = shr_v;
        res_carry = shr_bit;
      end
      default: begin
        result    = '0;
        res_carry = 1'b0;
      end
    endcase
  end

  assign res_zero = known && (result == '0);

  alu8_flagreg u_flags (
    .clk  (clk),
    .rst  (rst),
    .load (flag_we && known),
    .z_in (res_zero),
    .c_in (res_carry),
    .z_q  (zf_q),
    .c_q  (cf_q)
  );

endmodule

// File: rtl/alu8_checks.sv
module alu8_checks #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   op_sel,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         flag_we,
  input logic [W-1:0] result,
  input logic         res_zero,
  input logic         res_carry,
  input logic         zf_q,
  input logic         cf_q
);

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd0) |-> ({res_carry, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}))); // R1

  AST_SUB_COMPARE: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd1) |-> (res_carry == (opnd_a >= opnd_b))); // R2

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_sel inside {3'd2, 3'd3, 3'd4}) |-> !res_carry); // R3

  AST_SHIFT_FILL: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd5) |-> (!result[W-1] && (res_carry == opnd_a[0]))); // R4

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    (op_sel <= 3'd5) |-> (res_zero == (result == '0))); // R5

  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (op_sel > 3'd5) |=> $stable({zf_q, cf_q})); // R6

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable({zf_q, cf_q})); // R7

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_sel <= 3'd5) |=> ((zf_q == $past(res_zero)) && (cf_q == $past(res_carry)))); // R7

endmodule

bind alu8_core alu8_checks #(.W(W)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .op_sel    (op_sel),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .flag_we   (flag_we),
  .result    (result),
  .res_zero  (res_zero),
  .res_carry (res_carry),
  .zf_q      (zf_q),
  .cf_q      (cf_q)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] opnd_a = 8'd0;
  logic [7:0] opnd_b = 8'd0;
  logic       flag_we = 1'b0;
  logic [7:0] result;
  logic       res_zero, res_carry, zf_q, cf_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alu8_core dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .flag_we(flag_we), .result(result), .res_zero(res_zero),
    .res_carry(res_carry), .zf_q(zf_q), .cf_q(cf_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d",
               tag, op_sel, opnd_a, opnd_b, act, exp);
    end
  endtask

  task automatic edge_step(input logic r, input logic we, input logic [2:0] op,
                           input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    rst = r; flag_we = we; op_sel = op; opnd_a = a; opnd_b = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // reset with flag_we high and flag-setting operands: R8 priority
    edge_step(1'b1, 1'b1, 3'd0, 8'd255, 8'd1);
    chk("R8 reset zf", zf_q, 0);
    chk("R8 reset cf", cf_q, 0);
    edge_step(1'b0, 1'b1, 3'd0, 8'd255, 8'd1);
    chk("R7 load zf", zf_q, 1);
    chk("R7 load cf", cf_q, 1);
    edge_step(1'b0, 1'b0, 3'd2, 8'd1, 8'd1);
    chk("R7 hold zf", zf_q, 1);
    chk("R7 hold cf", cf_q, 1);
    edge_step(1'b0, 1'b1, 3'd6, 8'd3, 8'd9);
    chk("R6 unused hold zf", zf_q, 1);
    chk("R6 unused hold cf", cf_q, 1);
    edge_step(1'b0, 1'b1, 3'd1, 8'd3, 8'd5);
    chk("R7 sub load zf", zf_q, 0);
    chk("R7 sub load cf", cf_q, 0);
    edge_step(1'b0, 1'b1, 3'd5, 8'd1, 8'd0);
    chk("R7 shift load zf", zf_q, 1);
    chk("R7 shift load cf", cf_q, 1);
    edge_step(1'b1, 1'b0, 3'd0, 8'd0, 8'd0);
    chk("R8 clear zf", zf_q, 0);
    chk("R8 clear cf", cf_q, 0);
    edge_step(1'b0, 1'b0, 3'd0, 8'd0, 8'd0);

    // exhaustive combinational sweep, flag_we low
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          int er, ec, ez;
          op_sel = op[2:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
          #1;
          case (op)
            0: begin er = (a + b) & 255; ec = (a + b) >> 8; end
            1: begin er = (a - b) & 255; ec = (a >= b) ? 1 : 0; end
            2: begin er = a & b; ec = 0; end
            3: begin er = (~(a | b)) & 255; ec = 0; end
            4: begin er = a ^ b; ec = 0; end
            5: begin er = a / 2; ec = a % 2; end
            default: begin er = 0; ec = 0; end
          endcase
          ez = (op <= 5 && er == 0) ? 1 : 0;
          case (op)
            0: begin chk("R1 add result", result, er); chk("R1 add carry", res_carry, ec); end
            1: begin chk("R2 sub result", result, er); chk("R2 sub carry", res_carry, ec); end
            2, 3, 4: begin chk("R3 logic result", result, er); chk("R3 logic carry", res_carry, ec); end
            5: begin chk("R4 shift result", result, er); chk("R4 shift carry", res_carry, ec); end
            default: begin chk("R6 unused result", result, 0); chk("R6 unused carry", res_carry, 0); end
          endcase
          if (op <= 5) chk("R5 zero", res_zero, ez);
          else chk("R6 unused zero", res_zero, 0);
          #1;
        end
      end
    end

    // R9 identities
    for (int v = 0; v < 256; v++) begin
      op_sel = 3'd0; opnd_a = v[7:0]; opnd_b = 8'd255; #1;
      chk("R9 decrement", result, (v + 255) % 256);
      opnd_b = v[7:0]; #1;
      chk("R9 double", result, (2 * v) % 256);
      chk("R9 double carry", res_carry, v / 128);
      op_sel = 3'd3; opnd_b = 8'd0; #1;
      chk("R9 not", result, 255 - v);
      op_sel = 3'd1; opnd_a = 8'd0; opnd_b = v[7:0]; #1;
      chk("R9 negate", result, (256 - v) % 256);
      #1;
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule